// File: doc/BRIEF.md
# DRAM self-refresh entry/exit controller

This block moves an asynchronous DRAM into its low-power self-refresh state when the host asks it to sleep. It brings the memory back out when the host asks it to wake. On entry it takes over the row and column strobes. It drops the column strobe first, then the row strobe, and keeps the row strobe low for at least the minimum self-refresh width. On exit it raises both strobes and keeps the row strobe high for the self-refresh precharge time. It then asks the separate refresh engine for one refresh, or for a whole burst when the system runs burst refresh.

Three refresh schemes are supported, and each has its own limit on how long the memory may go without a refresh around the self-refresh period. The controller watches the refresh-completion pulses from the rest of the memory subsystem. If the allowed gap has already run out when a sleep request arrives, it first requests one extra refresh (or one extra burst) and only then enters self refresh. The first refresh after exit is requested immediately after the precharge time. The status output stays high until that refresh work is complete, so the host never issues an access too early.

The strobes driven here are meant to go through a mux controlled by `own_bus`. While `own_bus` is high, the other memory blocks keep their strobes inactive and their data drivers high impedance.

Top module: `srx_ctrl`

## Requirements
- R1: After reset `ras_n` and `cas_n` are 1, and `ref_req`, `own_bus` and `in_sr` are 0.
- R2: On entry, `cas_n` is low with `ras_n` high for exactly CSR_CYC cycles, and then both are low. `own_bus` is 1 from the fall of `cas_n` until the precharge time ends, and `ras_n` never falls while `cas_n` is high.
- R3: `ras_n` stays low for at least MIN_LOW_CYC cycles. A `wake_req` sampled before that minimum is dropped. A `wake_req` held from the start of the hold phase gives a low time of exactly MIN_LOW_CYC cycles.
- R4: After `ras_n` rises at exit it stays high for exactly PRE_CYC cycles before `ref_req` rises.
- R5: After exit, `ref_req` stays high until 1 `ref_done` pulse has been seen in the distributed schemes, or BURST_LEN pulses in the burst scheme.
- R6: `in_sr` rises with the fall of `ras_n` and falls on the cycle after the last exit `ref_done`. `ref_req` is 0 once `in_sr` is 0.
- R7: With `scheme` = 0 (column-before-row distributed), a sleep request causes one extra refresh before entry when the cycles since the last `ref_done`, plus CSR_CYC+1, reach ENTRY_CBR_CYC.
- R8: With `scheme` = 1 (row-only distributed), the same rule applies with the tighter limit ENTRY_RO_CYC.
- R9: With `scheme` = 2 or 3 (burst), the gap is measured from the first `ref_done` of a burst. A burst starts with a `ref_done` that follows at least QUIET_CYC cycles with no refresh. An extra burst of BURST_LEN refreshes is run when the gap reaches BURST_WIN_CYC/2.
- R10: When no `ref_done` has been seen since reset, the first sleep request always triggers the extra refresh first.
- R11: `scheme` is captured when the sleep request is accepted. Changing it later does not change the exit refresh count.
- R12: `sleep_req` is ignored outside idle and is not remembered. `wake_req` is ignored outside the hold phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Host request to enter self refresh, sampled in idle |
| wake_req | input | 1 | Host request to leave self refresh, sampled in the hold phase |
| scheme | input | 2 | Refresh scheme: 0 column-before-row distributed, 1 row-only distributed, 2 or 3 burst |
| ref_done | input | 1 | One-cycle pulse for every refresh completed by the refresh engine |
| ref_req | output | 1 | Request to the refresh engine, held until the needed pulses arrive |
| ras_n | output | 1 | Row strobe driven while the bus is owned |
| cas_n | output | 1 | Column strobe driven while the bus is owned |
| own_bus | output | 1 | Strobe mux select; other blocks release the strobes and data pins |
| in_sr | output | 1 | Memory is in self refresh or its exit refresh is still pending |

## Verification
A wrong sequencer state shows up as a strobe edge out of order or at the wrong cycle. The CAS-only interval, the row-low width and the precharge interval are each visible as exact cycle counts on the strobes within one exit. A corrupted gap timer does not show until the next sleep request. It then appears as a missing or surplus refresh pulse before the strobes move. The bench therefore steps each scheme just below and well above its limit. A wrong refresh tally shows as `in_sr` dropping early or late relative to the count of `ref_done` pulses.

// File: rtl/srx_pkg.sv
`timescale 1ns/1ps
package srx_pkg;

   typedef enum logic [2:0] {
      SX_IDLE    = 3'd0,
      SX_PREREF  = 3'd1,
      SX_CASSU   = 3'd2,
      SX_HOLD    = 3'd3,
      SX_PRECH   = 3'd4,
      SX_POSTREF = 3'd5
   } srx_state_e;

   localparam logic [1:0] SCH_CBR     = 2'd0;
   localparam logic [1:0] SCH_RASONLY = 2'd1;
   localparam logic [1:0] SCH_BURST   = 2'd2;

endpackage

// File: rtl/srx_count.sv
`timescale 1ns/1ps
module srx_count #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);

   localparam logic [W-1:0] TOP = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (inc && (cnt != TOP))
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/srx_gap_timer.sv
`timescale 1ns/1ps
module srx_gap_timer
   import srx_pkg::*;
#(
   parameter int TW        = 8,
   parameter int QUIET_CYC = 64,
   parameter int LIM_CBR   = 100,
   parameter int LIM_RO    = 50,
   parameter int LIM_BURST = 200,
   parameter int ENTRY_LAT = 3,
   parameter bit BURST_EN  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_done,
   input  logic [1:0] scheme,
   output logic       expired
);

   localparam int QW = $clog2(QUIET_CYC + 1);
   localparam logic [QW-1:0] QSAT    = QW'(QUIET_CYC);
   localparam logic [TW-1:0] GSAT    = {TW{1'b1}};
   localparam logic [TW:0]   LAT_V   = (TW+1)'(ENTRY_LAT);
   localparam logic [TW:0]   LCBR_V  = (TW+1)'(LIM_CBR);
   localparam logic [TW:0]   LRO_V   = (TW+1)'(LIM_RO);
   localparam logic [TW:0]   LBST_V  = (TW+1)'(LIM_BURST);

   logic [QW-1:0] quiet;
   logic [TW-1:0] gap;
   logic          restart;
   logic [TW:0]   lim;
   logic [TW:0]   reach;

   // Burst support decides whether the gap restarts on every refresh or
   // only on the first refresh after a quiet interval.
   generate
      if (BURST_EN) begin : g_burst
         assign restart = ref_done & (~scheme[1] | (quiet == QSAT));
      end else begin : g_flat
         assign restart = ref_done;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         quiet <= QSAT;
      else if (ref_done)
         quiet <= '0;
      else if (quiet != QSAT)
         quiet <= quiet + 1'b1;
   end

   // Saturated after reset: no refresh seen yet counts as an expired gap.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gap <= GSAT;
      else if (restart)
         gap <= '0;
      else if (gap != GSAT)
         gap <= gap + 1'b1;
   end

   always_comb begin
      case (scheme)
         SCH_CBR:     lim = LCBR_V;
         SCH_RASONLY: lim = LRO_V;
         default:     lim = BURST_EN ? LBST_V : LCBR_V;
      endcase
   end

   assign reach   = {1'b0, gap} + LAT_V;
   assign expired = (reach >= lim);

endmodule

// File: rtl/srx_seq.sv
`timescale 1ns/1ps
module srx_seq
   import srx_pkg::*;
#(
   parameter int PW          = 8,
   parameter int RW          = 4,
   parameter int CSR_CYC     = 2,
   parameter int MIN_LOW_CYC = 25000,
   parameter int PRE_CYC     = 28,
   parameter int BURST_LEN   = 1024,
   parameter bit BURST_EN    = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sleep_req,
   input  logic          wake_req,
   input  logic          expired,
   input  logic          scheme_burst,
   input  logic          ref_done,
   input  logic [PW-1:0] phase_cnt,
   input  logic [RW-1:0] ref_cnt,
   output srx_state_e    state,
   output logic          advance
);

   localparam logic [PW-1:0] CSR_LAST   = PW'(CSR_CYC - 1);
   localparam logic [PW-1:0] LOW_LAST   = PW'(MIN_LOW_CYC - 1);
   localparam logic [PW-1:0] PRE_LAST   = PW'(PRE_CYC - 1);
   localparam logic [RW-1:0] BURST_LAST = RW'(BURST_LEN - 1);

   srx_state_e    state_d;
   logic          burst_q;
   logic [RW-1:0] need_last;
   logic          refs_met;

   generate
      if (BURST_EN) begin : g_need_burst
         assign need_last = burst_q ? BURST_LAST : '0;
      end else begin : g_need_single
         assign need_last = '0;
      end
   endgenerate

   assign refs_met = ref_done && (ref_cnt >= need_last);

   always_comb begin
      state_d = state;
      unique case (state)
         SX_IDLE:    if (sleep_req) state_d = expired ? SX_PREREF : SX_CASSU;
         SX_PREREF:  if (refs_met) state_d = SX_CASSU;
         SX_CASSU:   if (phase_cnt >= CSR_LAST) state_d = SX_HOLD;
         SX_HOLD:    if (wake_req && (phase_cnt >= LOW_LAST)) state_d = SX_PRECH;
         SX_PRECH:   if (phase_cnt >= PRE_LAST) state_d = SX_POSTREF;
         SX_POSTREF: if (refs_met) state_d = SX_IDLE;
         default:    state_d = SX_IDLE;
      endcase
   end

   assign advance = (state_d != state);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SX_IDLE;
         burst_q <= 1'b0;
      end else begin
         state <= state_d;
         if ((state == SX_IDLE) && sleep_req)
            burst_q <= scheme_burst;
      end
   end

endmodule

// File: rtl/srx_ctrl.sv
`timescale 1ns/1ps
module srx_ctrl
   import srx_pkg::*;
#(
   parameter int MIN_LOW_CYC   = 25000,
   parameter int PRE_CYC       = 28,
   parameter int CSR_CYC       = 2,
   parameter int ENTRY_CBR_CYC = 31250,
   parameter int ENTRY_RO_CYC  = 4000,
   parameter int BURST_WIN_CYC = 4100000,
   parameter int BURST_LEN     = 1024,
   parameter int QUIET_CYC     = 64,
   parameter bit BURST_EN      = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_req,
   input  logic       wake_req,
   input  logic [1:0] scheme,
   input  logic       ref_done,
   output logic       ref_req,
   output logic       ras_n,
   output logic       cas_n,
   output logic       own_bus,
   output logic       in_sr
);

   localparam int ENTRY_LAT   = CSR_CYC + 1;
   localparam int BURST_ENTRY = BURST_WIN_CYC / 2;
   localparam int LIM_A       = (ENTRY_CBR_CYC > ENTRY_RO_CYC) ? ENTRY_CBR_CYC : ENTRY_RO_CYC;
   localparam int LIM_MAX     = (BURST_EN && (BURST_ENTRY > LIM_A)) ? BURST_ENTRY : LIM_A;
   localparam int TW          = $clog2(LIM_MAX + ENTRY_LAT + 1) + 1;
   localparam int PH_A        = (MIN_LOW_CYC > PRE_CYC) ? MIN_LOW_CYC : PRE_CYC;
   localparam int PH_MAX      = (PH_A > CSR_CYC) ? PH_A : CSR_CYC;
   localparam int PW          = $clog2(PH_MAX + 1);
   localparam int RW          = $clog2(BURST_LEN + 1);

   generate
      if ((MIN_LOW_CYC < 1) || (PRE_CYC < 1) || (CSR_CYC < 1) ||
          (BURST_LEN < 1) || (QUIET_CYC < 1)) begin : g_bad_cycles
         $error("srx_ctrl: every cycle-count parameter must be at least 1");
      end
      if ((ENTRY_RO_CYC <= ENTRY_LAT) || (ENTRY_CBR_CYC <= ENTRY_LAT)) begin : g_bad_window
         $error("srx_ctrl: entry windows must exceed the entry latency");
      end
   endgenerate

   srx_state_e    state;
   logic          advance;
   logic          expired;
   logic          phase_clr;
   logic          ref_clr;
   logic [PW-1:0] phase_cnt;
   logic [RW-1:0] ref_cnt;

   srx_gap_timer #(
      .TW        (TW),
      .QUIET_CYC (QUIET_CYC),
      .LIM_CBR   (ENTRY_CBR_CYC),
      .LIM_RO    (ENTRY_RO_CYC),
      .LIM_BURST (BURST_ENTRY),
      .ENTRY_LAT (ENTRY_LAT),
      .BURST_EN  (BURST_EN)
   ) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_done (ref_done),
      .scheme   (scheme),
      .expired  (expired)
   );

   srx_seq #(
      .PW          (PW),
      .RW          (RW),
      .CSR_CYC     (CSR_CYC),
      .MIN_LOW_CYC (MIN_LOW_CYC),
      .PRE_CYC     (PRE_CYC),
      .BURST_LEN   (BURST_LEN),
      .BURST_EN    (BURST_EN)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .sleep_req    (sleep_req),
      .wake_req     (wake_req),
      .expired      (expired),
      .scheme_burst (scheme[1]),
      .ref_done     (ref_done),
      .phase_cnt    (phase_cnt),
      .ref_cnt      (ref_cnt),
      .state        (state),
      .advance      (advance)
   );

   assign phase_clr = advance || (state == SX_IDLE);
   assign ref_clr   = advance || (state == SX_IDLE);

   srx_count #(.W(PW)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (phase_clr),
      .inc   (1'b1),
      .cnt   (phase_cnt)
   );

   srx_count #(.W(RW)) u_refs (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ref_clr),
      .inc   (ref_done),
      .cnt   (ref_cnt)
   );

   always_comb begin
      own_bus = (state == SX_CASSU) || (state == SX_HOLD) || (state == SX_PRECH);
      cas_n   = !((state == SX_CASSU) || (state == SX_HOLD));
      ras_n   = (state != SX_HOLD);
      ref_req = (state == SX_PREREF) || (state == SX_POSTREF);
      in_sr   = (state == SX_HOLD) || (state == SX_PRECH) || (state == SX_POSTREF);
   end

endmodule

// File: rtl/srx_ctrl_chk.sv
`timescale 1ns/1ps
module srx_ctrl_chk #(
   parameter int MIN_LOW_CYC = 25000,
   parameter int PRE_CYC     = 28
) (
   input logic clk,
   input logic rst_n,
   input logic ras_n,
   input logic cas_n,
   input logic own_bus,
   input logic ref_req,
   input logic ref_done,
   input logic in_sr
);

   int unsigned low_cnt;
   int unsigned high_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt  <= 0;
         high_cnt <= 0;
      end else begin
         low_cnt  <= ras_n ? 0 : low_cnt + 1;
         high_cnt <= ras_n ? high_cnt + 1 : 0;
      end
   end

   // R2: column strobe already low when the row strobe falls
   a_r2_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> ($past(!cas_n) && !cas_n));

   // R2: during the CAS-only phase the row strobe is still high
   a_r2_entry_ras_high: assert property (@(posedge clk) disable iff (!rst_n)
      (own_bus && !in_sr) |-> ras_n);

   // R3: low width of the row strobe
   a_r3_min_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |-> (low_cnt >= MIN_LOW_CYC));

   // R4: precharge before the exit refresh request
   a_r4_precharge: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ref_req) && in_sr) |-> (high_cnt >= PRE_CYC));

   // R6: status drops only right after a completed refresh
   a_r6_status_drop: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_sr) |-> $past(ref_done));

   // R6: row strobe low only inside the self-refresh status
   a_r6_low_in_sr: assert property (@(posedge clk) disable iff (!rst_n)
      !ras_n |-> in_sr);

   // R5: refresh is requested only with the bus released
   a_r5_req_released: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req |-> (!own_bus && ras_n));

endmodule

bind srx_ctrl srx_ctrl_chk #(
   .MIN_LOW_CYC (MIN_LOW_CYC),
   .PRE_CYC     (PRE_CYC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ras_n    (ras_n),
   .cas_n    (cas_n),
   .own_bus  (own_bus),
   .ref_req  (ref_req),
   .ref_done (ref_done),
   .in_sr    (in_sr)
);

// File: tb/sim_srx_ctrl.sv
`timescale 1ns/1ps
module sim_srx_ctrl;

   localparam int MIN_LOW   = 20;
   localparam int PRE       = 3;
   localparam int CSR       = 2;
   localparam int LIM_CBR   = 40;
   localparam int LIM_RO    = 15;
   localparam int BWIN      = 200;
   localparam int BLEN      = 4;
   localparam int QUIET     = 10;

   typedef struct packed {
      logic [1:0] sch;
      logic [7:0] gap;
      logic [3:0] extra;
      logic [3:0] exits;
   } row_t;

   localparam int NROWS = 8;
   localparam row_t ROWS [NROWS] = '{
      '{sch: 2'd0, gap: 8'd0,   extra: 4'd1, exits: 4'd1},
      '{sch: 2'd0, gap: 8'd5,   extra: 4'd0, exits: 4'd1},
      '{sch: 2'd0, gap: 8'd20,  extra: 4'd0, exits: 4'd1},
      '{sch: 2'd0, gap: 8'd60,  extra: 4'd1, exits: 4'd1},
      '{sch: 2'd1, gap: 8'd5,   extra: 4'd0, exits: 4'd1},
      '{sch: 2'd1, gap: 8'd20,  extra: 4'd1, exits: 4'd1},
      '{sch: 2'd2, gap: 8'd50,  extra: 4'd0, exits: 4'd4},
      '{sch: 2'd2, gap: 8'd130, extra: 4'd4, exits: 4'd4}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sleep_req = 1'b0;
   logic       wake_req = 1'b0;
   logic [1:0] scheme = 2'd0;
   logic       man_done = 1'b0;
   logic       auto_done = 1'b0;
   logic [1:0] rd_dly = 2'd0;
   logic       ref_done;
   logic       ref_req, ras_n, cas_n, own_bus, in_sr;

   int checks = 0;
   int errors = 0;
   int n_done = 0;
   bit finished = 1'b0;

   assign ref_done = man_done | auto_done;

   always #2 clk = ~clk;

   srx_ctrl #(
      .MIN_LOW_CYC   (MIN_LOW),
      .PRE_CYC       (PRE),
      .CSR_CYC       (CSR),
      .ENTRY_CBR_CYC (LIM_CBR),
      .ENTRY_RO_CYC  (LIM_RO),
      .BURST_WIN_CYC (BWIN),
      .BURST_LEN     (BLEN),
      .QUIET_CYC     (QUIET),
      .BURST_EN      (1'b1)
   ) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep_req (sleep_req),
      .wake_req  (wake_req),
      .scheme    (scheme),
      .ref_done  (ref_done),
      .ref_req   (ref_req),
      .ras_n     (ras_n),
      .cas_n     (cas_n),
      .own_bus   (own_bus),
      .in_sr     (in_sr)
   );

   // refresh engine model: answers each request two cycles later
   always @(posedge clk) begin
      if (!ref_req || auto_done) begin
         rd_dly    <= 2'd0;
         auto_done <= 1'b0;
      end else if (rd_dly == 2'd1) begin
         auto_done <= 1'b1;
         rd_dly    <= 2'd0;
      end else begin
         rd_dly <= rd_dly + 2'd1;
      end
   end

   always @(posedge clk) if (ref_done) n_done <= n_done + 1;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_done();
      @(negedge clk) man_done = 1'b1;
      @(negedge clk) man_done = 1'b0;
   endtask

   task automatic pulse_sleep();
      @(negedge clk) sleep_req = 1'b1;
      @(negedge clk) sleep_req = 1'b0;
   endtask

   task automatic pulse_wake();
      @(negedge clk) wake_req = 1'b1;
      @(negedge clk) wake_req = 1'b0;
   endtask

   task automatic wait_sr(input bit lvl);
      for (int g = 0; g < 1000 && in_sr != lvl; g++) @(negedge clk);
   endtask

   task automatic run_row(input row_t r);
      string tag;
      int d0, d1, csu, low, pc;
      if (r.gap == 8'd0)       tag = "R10";
      else if (r.sch == 2'd0)  tag = "R7";
      else if (r.sch == 2'd1)  tag = "R8";
      else                     tag = "R9";
      @(negedge clk) scheme = r.sch;
      idle(QUIET + 5);
      if (r.gap != 8'd0) begin
         if (r.sch[1]) begin
            for (int p = 0; p < BLEN; p++) begin
               pulse_done();
               idle(2);
            end
            idle(int'(r.gap) - 16);
         end else begin
            pulse_done();
            idle(int'(r.gap) - 2);
         end
      end
      d0 = n_done;
      pulse_sleep();
      csu = 0;
      for (int g = 0; g < 1000 && !in_sr; g++) begin
         if (!cas_n && ras_n) csu++;
         @(negedge clk);
      end
      chk(tag, "refreshes before entry", n_done - d0, int'(r.extra));
      chk("R2", "CAS-only cycles", csu, CSR);
      chk("R2", "strobes low and bus owned", {ras_n, cas_n, own_bus}, 3'b001);
      wake_req = 1'b1;
      low = 0;
      for (int g = 0; g < 1000 && !ras_n; g++) begin
         low++;
         @(negedge clk);
      end
      wake_req = 1'b0;
      chk("R3", "row strobe low cycles", low, MIN_LOW);
      pc = 0;
      for (int g = 0; g < 1000 && !ref_req; g++) begin
         pc++;
         @(negedge clk);
      end
      chk("R4", "precharge cycles", pc, PRE);
      d1 = n_done;
      wait_sr(1'b0);
      chk("R5", "exit refreshes", n_done - d1, int'(r.exits));
      chk("R6", "request low after status drop", int'(ref_req), 0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int d1;
      idle(3);
      chk("R1", "reset outputs", {ras_n, cas_n, ref_req, own_bus, in_sr}, 5'b11000);
      @(negedge clk) rst_n = 1'b1;
      idle(2);
      chk("R1", "outputs after release", {ras_n, cas_n, ref_req, own_bus, in_sr}, 5'b11000);

      foreach (ROWS[i]) run_row(ROWS[i]);

      // R12: wake in idle has no effect
      pulse_wake();
      idle(5);
      chk("R12", "idle after stray wake", {ras_n, cas_n, ref_req, own_bus, in_sr}, 5'b11000);

      // R3 / R12 / R11: early wake dropped, sleep in hold ignored, scheme frozen
      @(negedge clk) scheme = 2'd0;
      pulse_done();
      idle(3);
      pulse_sleep();
      wait_sr(1'b1);
      idle(3);
      pulse_wake();
      pulse_sleep();
      @(negedge clk) scheme = 2'd2;
      idle(MIN_LOW + 5);
      chk("R3", "early wake dropped", {int'(in_sr), int'(ras_n)}, {32'd1, 32'd0});
      pulse_wake();
      chk("R3", "late wake accepted", int'(ras_n), 1);
      for (int g = 0; g < 100 && !ref_req; g++) @(negedge clk);
      d1 = n_done;
      wait_sr(1'b0);
      chk("R11", "exit refreshes with frozen scheme", n_done - d1, 1);
      idle(10);
      chk("R12", "sleep in hold not remembered", {int'(own_bus), int'(in_sr), int'(cas_n)}, {32'd0, 32'd0, 32'd1});

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule